// File: doc/BRIEF.md
# Multi-port MDIO management slave with interrupt merge

This block is the station-management endpoint of a PHY that serves several ports. It runs on the management clock and samples the serial data line on every rising edge. It looks for a run of ones, then a start pattern, and then decodes the read or write request that follows. A request that names one of its ports either updates a small file of 16-bit registers or returns the addressed register on the data line. The master and slave share the line through an output value and an output enable. Off chip, a pull-up makes the released line read as one.

Each port collects four kinds of status-change pulse into sticky bits: link, auto-negotiation done, duplex change and jabber. A per-port enable bit gates these bits into a single active-low interrupt pin. A read of a port that has an enabled pending cause also flags this with one extra low bit after the data. A strap-mode input picks how the per-port control register is driven. In one setting the strap inputs only seed it at reset. In the other they drive it permanently and writes have no effect.

The line is a bit-serial shared wire and not a stream, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal.

Top module: `mgmt_slave`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive ones are sampled, followed by the start pattern 0 then 1. With 31 or fewer ones the frame is ignored.
- R2: The two bits after the start pattern are the opcode: 1,0 is a read and 0,1 is a write. A frame with opcode 0,0 or 1,1 is ignored.
- R3: Next come a 5-bit PHY address and a 5-bit register address, each sent MSB first. PHY addresses BASE_ADDR to BASE_ADDR+NPORTS-1 (8 to 11 by default) select ports 0 to NPORTS-1. For any other address the frame changes no register, and the output enable stays low for the whole frame.
- R4: On a read that hits a port, the slave leaves the first turnaround bit released and drives 0 in the second. It then drives the 16 data bits MSB first. Each driven value changes just after a rising edge and is held until the next one. The enable drops after the data, apart from the flag bit of R9.
- R5: On a write, the master sends two turnaround bits and then 16 data bits, MSB first. The data goes to the addressed register. The map is: 0 = control (read/write, also sent to ctrl_o), 17 = config (read/write, bit 1 = interrupt enable), 18 = interrupt status (read only). All other addresses read as 0 and ignore writes.
- R6: Register 18 holds sticky bits: bit 0 link change, bit 1 auto-negotiation done, bit 2 duplex change, bit 3 jabber. Each bit is set by a one-cycle pulse on the matching event input of that port.
- R7: A read of register 18 returns the sticky bits and then clears them. A second read returns 0 unless a new event has arrived.
- R8: int_n is low after any rising edge that leaves a port with its enable bit set and a sticky bit pending. It returns high once no enabled port has a pending bit. Events on a port whose enable is clear do not pull int_n low.
- R9: The bit after the 16 read data bits is the flag bit. The slave drives it 0 if the addressed port has an enabled pending bit once the read has been taken; otherwise it leaves the line released.
- R10: Reset loads the control register from that port's strap bits. With strap_hold low, writes may change it afterwards. With strap_hold high, the register and ctrl_o follow the strap bits one cycle later, and writes to register 0 have no effect.
- R11: If a 0 follows the first start bit instead of a 1, the frame is dropped, and a new run of 32 ones is needed before the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_in | input | 1 | Resolved level of the shared data line |
| mdio_out | output | 1 | Value the slave drives when enabled |
| mdio_oe | output | 1 | Slave output enable for the data line |
| strap_hold | input | 1 | 0: straps seed control at reset; 1: straps drive control permanently |
| strap_ctrl | input | NPORTS*16 | Strap value of each port's control register, port 0 in the low bits |
| ctrl_o | output | NPORTS*16 | Current control register of each port |
| ev_link | input | NPORTS | Link status change pulse per port |
| ev_aneg | input | NPORTS | Auto-negotiation complete pulse per port |
| ev_dplx | input | NPORTS | Duplex status change pulse per port |
| ev_jabber | input | NPORTS | Jabber detect pulse per port |
| int_n | output | 1 | Active-low merged interrupt |

## Verification
Well-formed reads and writes to each register class show that the addresses decode correctly. They show that read-only and unmapped registers ignore writes, and that bits come out MSB first with the turnaround zero in the right place. Malformed frames (a 31-bit preamble, a broken start pattern, the two illegal opcodes, PHY addresses just below and just above the port range) must leave the registers unchanged and the line undriven, which sets the hunting logic apart from the decoder. Event pulses on ports with the enable set and with it clear, followed by reads of other registers and then of the status register, show the sticky behaviour, the clear on read, the gating of int_n and the flag bit. Switching the strap mode shows whether a write or the strap pins win.

// File: rtl/mgmt_pkg.sv
`timescale 1ns/1ps
package mgmt_pkg;
  localparam int REG_W   = 16;
  localparam int RADDR_W = 5;
  localparam int PADDR_W = 5;
  localparam int OP_W    = 2;
  localparam int HDR_W   = OP_W + PADDR_W + RADDR_W;
  localparam int N_CAUSE = 4;

  localparam logic [OP_W-1:0] OP_READ  = 2'b10;
  localparam logic [OP_W-1:0] OP_WRITE = 2'b01;

  localparam logic [RADDR_W-1:0] RA_CTRL = 5'd0;
  localparam logic [RADDR_W-1:0] RA_CFG  = 5'd17;
  localparam logic [RADDR_W-1:0] RA_ISR  = 5'd18;
  localparam int CFG_IEN = 1;

  typedef enum logic [2:0] {
    RX_HUNT, RX_SFD, RX_HDR, RX_TA, RX_DATA, RX_FLAG
  } rx_state_e;
endpackage

// File: rtl/mgmt_frame_rx.sv
`timescale 1ns/1ps
module mgmt_frame_rx
  import mgmt_pkg::*;
#(
  parameter int NPORTS    = 4,
  parameter int BASE_ADDR = 8,
  parameter int PRE_LEN   = 32,
  parameter int PORT_W    = 2
) (
  input  logic                mdc,
  input  logic                rst_n,
  input  logic                mdio_in,
  input  logic [REG_W-1:0]    rd_data,
  input  logic [NPORTS-1:0]   pend_vec,
  output logic [PORT_W-1:0]   cur_port,
  output logic [RADDR_W-1:0]  cur_reg,
  output logic                rd_req,
  output logic [PORT_W-1:0]   wr_port,
  output logic [RADDR_W-1:0]  wr_reg,
  output logic                wr_en,
  output logic [REG_W-1:0]    wr_data,
  output logic                mdio_out,
  output logic                mdio_oe
);
  localparam int PRE_W = $clog2(PRE_LEN + 1);
  localparam int CNT_W = $clog2(REG_W);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(REG_W - 1);

  rx_state_e          state;
  logic [PRE_W-1:0]   pre_cnt;
  logic [CNT_W-1:0]   bitcnt;
  logic [HDR_W-2:0]   hdr_sr;
  logic [REG_W-1:0]   sr;
  logic               is_rd, hit_q;

  logic [HDR_W-1:0]   hdr_full;
  logic [OP_W-1:0]    op;
  logic [PADDR_W-1:0] phy;
  logic               hit, op_ok, hdr_done;

  assign hdr_full = {hdr_sr, mdio_in};
  assign op       = hdr_full[HDR_W-1 -: OP_W];
  assign phy      = hdr_full[RADDR_W +: PADDR_W];
  assign cur_reg  = hdr_full[RADDR_W-1:0];
  assign hit      = (int'(phy) >= BASE_ADDR) && (int'(phy) < BASE_ADDR + NPORTS);
  assign cur_port = PORT_W'(int'(phy) - BASE_ADDR);
  assign op_ok    = (op == OP_READ) || (op == OP_WRITE);
  assign hdr_done = (state == RX_HDR) && (bitcnt == HDR_LAST);
  assign rd_req   = hdr_done && (op == OP_READ) && hit;
  assign wr_en    = (state == RX_DATA) && (bitcnt == DATA_LAST) && !is_rd && hit_q;
  assign wr_data  = {sr[REG_W-2:0], mdio_in};

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_HUNT;
      pre_cnt  <= '0;
      bitcnt   <= '0;
      hdr_sr   <= '0;
      sr       <= '0;
      is_rd    <= 1'b0;
      hit_q    <= 1'b0;
      wr_port  <= '0;
      wr_reg   <= '0;
      mdio_out <= 1'b0;
      mdio_oe  <= 1'b0;
    end else begin
      case (state)
        RX_HUNT: begin
          mdio_oe <= 1'b0;
          if (mdio_in) begin
            if (pre_cnt != PRE_W'(PRE_LEN)) pre_cnt <= pre_cnt + 1'b1;
          end else if (pre_cnt == PRE_W'(PRE_LEN)) begin
            state <= RX_SFD;
          end else begin
            pre_cnt <= '0;
          end
        end
        RX_SFD: begin
          pre_cnt <= '0;
          bitcnt  <= '0;
          state   <= mdio_in ? RX_HDR : RX_HUNT;
        end
        RX_HDR: begin
          hdr_sr <= {hdr_sr[HDR_W-3:0], mdio_in};
          bitcnt <= bitcnt + 1'b1;
          if (hdr_done) begin
            bitcnt <= '0;
            if (op_ok) begin
              state   <= RX_TA;
              is_rd   <= (op == OP_READ);
              hit_q   <= hit;
              wr_port <= cur_port;
              wr_reg  <= cur_reg;
              if (rd_req) sr <= rd_data;
            end else begin
              state <= RX_HUNT;
            end
          end
        end
        RX_TA: begin
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == '0) begin
            if (is_rd && hit_q) begin
              mdio_oe  <= 1'b1;
              mdio_out <= 1'b0;
            end
          end else begin
            bitcnt <= '0;
            state  <= RX_DATA;
            if (is_rd) begin
              mdio_out <= sr[REG_W-1];
              sr       <= {sr[REG_W-2:0], 1'b0};
            end
          end
        end
        RX_DATA: begin
          bitcnt <= bitcnt + 1'b1;
          if (is_rd) begin
            if (bitcnt != DATA_LAST) begin
              mdio_out <= sr[REG_W-1];
              sr       <= {sr[REG_W-2:0], 1'b0};
            end
          end else begin
            sr <= wr_data;
          end
          if (bitcnt == DATA_LAST) begin
            if (is_rd) begin
              state    <= RX_FLAG;
              mdio_oe  <= hit_q && pend_vec[wr_port];
              mdio_out <= 1'b0;
            end else begin
              state <= RX_HUNT;
            end
          end
        end
        RX_FLAG: begin
          mdio_oe <= 1'b0;
          state   <= RX_HUNT;
        end
        default: state <= RX_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/mgmt_port_regs.sv
`timescale 1ns/1ps
module mgmt_port_regs
  import mgmt_pkg::*;
(
  input  logic               mdc,
  input  logic               rst_n,
  input  logic [REG_W-1:0]   strap,
  input  logic               strap_hold,
  input  logic               wr_en,
  input  logic [RADDR_W-1:0] wr_reg,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               rd_clr,
  input  logic [RADDR_W-1:0] rd_reg,
  input  logic [N_CAUSE-1:0] ev,
  output logic [REG_W-1:0]   rd_data,
  output logic [REG_W-1:0]   ctrl,
  output logic               int_en,
  output logic               pend
);
  logic [REG_W-1:0]   cfg;
  logic [N_CAUSE-1:0] isr;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= strap;
      cfg  <= '0;
      isr  <= '0;
    end else begin
      if (strap_hold) ctrl <= strap;
      else if (wr_en && wr_reg == RA_CTRL) ctrl <= wr_data;
      if (wr_en && wr_reg == RA_CFG) cfg <= wr_data;
      isr <= (rd_clr ? '0 : isr) | ev;
    end
  end

  always_comb begin
    case (rd_reg)
      RA_CTRL: rd_data = ctrl;
      RA_CFG:  rd_data = cfg;
      RA_ISR:  rd_data = REG_W'(isr);
      default: rd_data = '0;
    endcase
  end

  assign int_en = cfg[CFG_IEN];
  assign pend   = int_en && (|isr);
endmodule

// File: rtl/mgmt_irq_merge.sv
`timescale 1ns/1ps
module mgmt_irq_merge
  import mgmt_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  logic [NPORTS-1:0]               ev_link,
  input  logic [NPORTS-1:0]               ev_aneg,
  input  logic [NPORTS-1:0]               ev_dplx,
  input  logic [NPORTS-1:0]               ev_jabber,
  input  logic [NPORTS-1:0]               pend_vec,
  output logic [NPORTS-1:0][N_CAUSE-1:0]  ev_bus,
  output logic                            int_n
);
  for (genvar g = 0; g < NPORTS; g++) begin : g_pack
    assign ev_bus[g] = {ev_jabber[g], ev_dplx[g], ev_aneg[g], ev_link[g]};
  end
  assign int_n = ~(|pend_vec);
endmodule

// File: rtl/mgmt_slave.sv
`timescale 1ns/1ps
module mgmt_slave
  import mgmt_pkg::*;
#(
  parameter int NPORTS    = 4,
  parameter int BASE_ADDR = 8,
  parameter int PRE_LEN   = 32
) (
  input  logic                    mdc,
  input  logic                    rst_n,
  input  logic                    mdio_in,
  output logic                    mdio_out,
  output logic                    mdio_oe,
  input  logic                    strap_hold,
  input  logic [NPORTS*REG_W-1:0] strap_ctrl,
  output logic [NPORTS*REG_W-1:0] ctrl_o,
  input  logic [NPORTS-1:0]       ev_link,
  input  logic [NPORTS-1:0]       ev_aneg,
  input  logic [NPORTS-1:0]       ev_dplx,
  input  logic [NPORTS-1:0]       ev_jabber,
  output logic                    int_n
);
  localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  logic [PORT_W-1:0]  cur_port, wr_port;
  logic [RADDR_W-1:0] cur_reg, wr_reg;
  logic               rd_req, wr_en;
  logic [REG_W-1:0]   wr_data, rd_data;
  logic [REG_W-1:0]   rd_vec [NPORTS];
  logic [NPORTS-1:0]  pend_vec, int_en_vec;
  logic [NPORTS-1:0][N_CAUSE-1:0] ev_bus;

  mgmt_frame_rx #(
    .NPORTS(NPORTS), .BASE_ADDR(BASE_ADDR), .PRE_LEN(PRE_LEN), .PORT_W(PORT_W)
  ) u_rx (
    .mdc(mdc), .rst_n(rst_n), .mdio_in(mdio_in),
    .rd_data(rd_data), .pend_vec(pend_vec),
    .cur_port(cur_port), .cur_reg(cur_reg), .rd_req(rd_req),
    .wr_port(wr_port), .wr_reg(wr_reg), .wr_en(wr_en), .wr_data(wr_data),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    mgmt_port_regs u_regs (
      .mdc(mdc), .rst_n(rst_n),
      .strap(strap_ctrl[g*REG_W +: REG_W]), .strap_hold(strap_hold),
      .wr_en(wr_en && (wr_port == PORT_W'(g))), .wr_reg(wr_reg), .wr_data(wr_data),
      .rd_clr(rd_req && (cur_port == PORT_W'(g)) && (cur_reg == RA_ISR)),
      .rd_reg(cur_reg), .ev(ev_bus[g]),
      .rd_data(rd_vec[g]), .ctrl(ctrl_o[g*REG_W +: REG_W]),
      .int_en(int_en_vec[g]), .pend(pend_vec[g])
    );
  end

  assign rd_data = rd_vec[cur_port];

  mgmt_irq_merge #(.NPORTS(NPORTS)) u_irq (
    .ev_link(ev_link), .ev_aneg(ev_aneg), .ev_dplx(ev_dplx), .ev_jabber(ev_jabber),
    .pend_vec(pend_vec), .ev_bus(ev_bus), .int_n(int_n)
  );
endmodule

// File: rtl/mgmt_slave_chk.sv
`timescale 1ns/1ps
module mgmt_slave_chk #(
  parameter int NPORTS = 4,
  parameter int REG_W  = 16
) (
  input logic                    mdc,
  input logic                    rst_n,
  input logic                    mdio_oe,
  input logic                    mdio_out,
  input logic                    int_n,
  input logic                    strap_hold,
  input logic [NPORTS*REG_W-1:0] strap_ctrl,
  input logic [NPORTS*REG_W-1:0] ctrl_o,
  input logic [NPORTS-1:0]       ev_link,
  input logic [NPORTS-1:0]       ev_aneg,
  input logic [NPORTS-1:0]       ev_dplx,
  input logic [NPORTS-1:0]       ev_jabber,
  input logic [NPORTS-1:0]       int_en,
  input logic                    rd_req,
  input logic                    wr_en
);
  logic [4:0] oe_run;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) oe_run <= '0;
    else if (!mdio_oe) oe_run <= '0;
    else if (oe_run != 5'd31) oe_run <= oe_run + 1'b1;
  end

  AST_TA_DRIVES_ZERO: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_out); // R4

  AST_DRIVE_WINDOW: assert property (@(posedge mdc) disable iff (!rst_n)
    oe_run <= 5'd18); // R4

  AST_EVENT_PULLS_INT: assert property (@(posedge mdc) disable iff (!rst_n)
    ((|((ev_link | ev_aneg | ev_dplx | ev_jabber) & int_en)) && !wr_en) |=> !int_n); // R8

  AST_INT_RELEASE_CAUSE: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(int_n) |-> $past(rd_req || wr_en)); // R7

  AST_STRAP_OVERRIDE: assert property (@(posedge mdc) disable iff (!rst_n)
    (strap_hold && $past(strap_hold)) |-> (ctrl_o == $past(strap_ctrl))); // R10
endmodule

bind mgmt_slave mgmt_slave_chk #(.NPORTS(NPORTS), .REG_W(mgmt_pkg::REG_W)) u_chk (
  .mdc(mdc), .rst_n(rst_n), .mdio_oe(mdio_oe), .mdio_out(mdio_out), .int_n(int_n),
  .strap_hold(strap_hold), .strap_ctrl(strap_ctrl), .ctrl_o(ctrl_o),
  .ev_link(ev_link), .ev_aneg(ev_aneg), .ev_dplx(ev_dplx), .ev_jabber(ev_jabber),
  .int_en(int_en_vec), .rd_req(rd_req), .wr_en(wr_en)
);

// File: tb/tb_mgmt_slave.sv
`timescale 1ns/1ps
module tb_mgmt_slave;
  localparam int NP = 4;

  logic mdc = 1'b0;
  always #10 mdc = ~mdc;

  logic rst_n, m_en, m_bit, line;
  logic mdio_out, mdio_oe, strap_hold, int_n;
  logic [NP*16-1:0] strap_ctrl, ctrl_o;
  logic [NP-1:0] ev_link, ev_aneg, ev_dplx, ev_jabber;

  assign line = mdio_oe ? mdio_out : (m_en ? m_bit : 1'b1);

  mgmt_slave dut (
    .mdc(mdc), .rst_n(rst_n), .mdio_in(line), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .strap_hold(strap_hold), .strap_ctrl(strap_ctrl), .ctrl_o(ctrl_o),
    .ev_link(ev_link), .ev_aneg(ev_aneg), .ev_dplx(ev_dplx), .ev_jabber(ev_jabber),
    .int_n(int_n)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [16:0] exp_q[$];
  string tag_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    @(negedge mdc); m_en = 1'b1; m_bit = b;
  endtask

  task automatic frame(input int pre, input logic [1:0] sfd, input logic [1:0] op,
                       input logic [4:0] phy, input logic [4:0] ra,
                       input bit rd, input logic [15:0] data);
    repeat (pre) bit_out(1'b1);
    bit_out(sfd[1]); bit_out(sfd[0]);
    bit_out(op[1]);  bit_out(op[0]);
    for (int i = 4; i >= 0; i--) bit_out(phy[i]);
    for (int i = 4; i >= 0; i--) bit_out(ra[i]);
    if (rd) begin
      repeat (19) begin @(negedge mdc); m_en = 1'b0; end
    end else begin
      bit_out(1'b1); bit_out(1'b0);
      for (int i = 15; i >= 0; i--) bit_out(data[i]);
    end
  endtask

  task automatic wr(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    frame(32, 2'b01, 2'b01, phy, ra, 0, d);
  endtask

  task automatic rd(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d,
                    input logic fl, input string tag);
    exp_q.push_back({fl, d});
    tag_q.push_back(tag);
    frame(32, 2'b01, 2'b10, phy, ra, 1, 16'h0);
  endtask

  task automatic pulse(input int kind, input int p);
    @(negedge mdc);
    m_en = 1'b0;
    case (kind)
      0: ev_link[p] = 1'b1;
      1: ev_aneg[p] = 1'b1;
      2: ev_dplx[p] = 1'b1;
      default: ev_jabber[p] = 1'b1;
    endcase
    @(negedge mdc);
    ev_link = '0; ev_aneg = '0; ev_dplx = '0; ev_jabber = '0;
  endtask

  // monitor: pops expected read results as the slave drives them
  initial begin
    logic [15:0] got;
    logic fl, ta_zero, gap;
    logic [16:0] e;
    string t;
    forever begin
      @(negedge mdc);
      if (rst_n && mdio_oe) begin
        ta_zero = !mdio_out;
        gap = 1'b0;
        for (int i = 15; i >= 0; i--) begin
          @(negedge mdc);
          got[i] = mdio_out;
          if (!mdio_oe) gap = 1'b1;
        end
        @(negedge mdc);
        fl = mdio_oe && !mdio_out;
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R3 unexpected drive actual=%h expected=none", {fl, got});
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({t, " R4 turnaround zero"}, 32'(ta_zero), 32'd1);
          check({t, " R4 data window driven"}, 32'(gap), 32'd0);
          check(t, 32'({fl, got}), 32'(e));
        end
      end
    end
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge mdc);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; m_en = 1'b0; m_bit = 1'b1; strap_hold = 1'b0;
    ev_link = '0; ev_aneg = '0; ev_dplx = '0; ev_jabber = '0;
    strap_ctrl = {16'h4433, 16'h3322, 16'h2211, 16'h1100};
    repeat (3) @(negedge mdc);
    rst_n = 1'b1;
    @(negedge mdc);
    check("R8 reset int_n high", 32'(int_n), 32'd1);
    check("R4 reset line released", 32'(mdio_oe), 32'd0);
    check("R10 reset seeds control", 32'(ctrl_o[31:0]), 32'h2211_1100);

    rd(8, 0, 16'h1100, 1'b0, "R1 read strap seed port0");
    wr(9, 0, 16'hA5C3);
    rd(9, 0, 16'hA5C3, 1'b0, "R5 control readback");
    check("R5 control output", 32'(ctrl_o[31:16]), 32'hA5C3);

    wr(20, 0, 16'hFFFF);
    wr(12, 0, 16'h0000);
    wr(7, 0, 16'h0000);
    frame(32, 2'b01, 2'b10, 20, 0, 1, 16'h0);
    rd(9, 0, 16'hA5C3, 1'b0, "R3 foreign write ignored");
    rd(11, 0, 16'h4433, 1'b0, "R3 address above range");
    rd(8, 0, 16'h1100, 1'b0, "R3 address below range");

    frame(31, 2'b01, 2'b01, 8, 0, 0, 16'h1234);
    rd(8, 0, 16'h1100, 1'b0, "R1 short preamble ignored");
    frame(32, 2'b00, 2'b01, 8, 0, 0, 16'h1234);
    rd(8, 0, 16'h1100, 1'b0, "R11 bad start pattern ignored");
    frame(32, 2'b01, 2'b11, 8, 0, 0, 16'h1234);
    frame(32, 2'b01, 2'b00, 8, 0, 0, 16'h1234);
    rd(8, 0, 16'h1100, 1'b0, "R2 illegal opcodes ignored");

    wr(10, 5, 16'hBEEF);
    rd(10, 5, 16'h0000, 1'b0, "R5 unmapped register");
    wr(10, 18, 16'h000F);
    rd(10, 18, 16'h0000, 1'b0, "R6 status not writable");

    pulse(0, 2);
    check("R8 disabled port keeps int_n high", 32'(int_n), 32'd1);
    rd(10, 18, 16'h0001, 1'b0, "R6 link bit");
    rd(10, 18, 16'h0000, 1'b0, "R7 cleared by read");

    wr(10, 17, 16'h0002);
    rd(10, 17, 16'h0002, 1'b0, "R5 config readback");
    pulse(1, 2);
    check("R8 enabled event pulls int_n", 32'(int_n), 32'd0);
    pulse(3, 2);
    rd(10, 0, 16'h3322, 1'b1, "R9 flag bit on pending port");
    check("R7 other reads keep pending", 32'(int_n), 32'd0);
    rd(10, 18, 16'h000A, 1'b0, "R7 aneg and jabber bits");
    check("R8 int_n released after clear", 32'(int_n), 32'd1);

    pulse(2, 0);
    check("R8 duplex on disabled port", 32'(int_n), 32'd1);
    rd(8, 18, 16'h0004, 1'b0, "R6 duplex bit");
    wr(11, 17, 16'h0002);
    pulse(0, 3);
    check("R8 second port pulls int_n", 32'(int_n), 32'd0);
    rd(11, 18, 16'h0001, 1'b0, "R6 port3 link bit");
    check("R8 second port release", 32'(int_n), 32'd1);
    rd(11, 0, 16'h4433, 1'b0, "R9 no flag without pending");

    @(negedge mdc);
    strap_hold = 1'b1;
    strap_ctrl[15:0] = 16'h7E81;
    repeat (2) @(negedge mdc);
    check("R10 hold follows strap", 32'(ctrl_o[15:0]), 32'h7E81);
    check("R10 hold overrides written value", 32'(ctrl_o[31:16]), 32'h2211);
    wr(8, 0, 16'h0F0F);
    check("R10 write ignored in hold", 32'(ctrl_o[15:0]), 32'h7E81);
    rd(8, 0, 16'h7E81, 1'b0, "R10 read in hold");
    @(negedge mdc);
    strap_hold = 1'b0;
    wr(8, 0, 16'h0F0F);
    rd(8, 0, 16'h0F0F, 1'b0, "R10 writes after hold released");

    repeat (4) @(negedge mdc);
    check("R4 every read answered", 32'(exp_q.size()), 32'd0);
    done = 1;
    summary();
    $finish;
  end
endmodule